// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, a 16-bit segment selector paired with an offset, into a linear address. A 2-bit mode input chooses how the segment base is formed. In real mode and virtual-8086 mode the base is the selector shifted left by four bits. In protected mode the selector points at an 8-byte descriptor held in either the global or the local descriptor table in memory, and the base is taken from that descriptor. Alongside each result the block raises a flag that says whether the address is already physical or must still go through page translation.

The selector can come straight from the request, or from one of four segment registers held inside the block. Loading a segment register stores its selector. In protected mode the load also fetches the descriptor and caches its base, so later translations through that register finish in one cycle with no memory traffic. Descriptors are fetched through a single 64-bit read port that uses a request/acknowledge handshake. Only one operation is in flight at a time, and `idle` shows when a new request will be taken.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `out_valid` and `mem_req` are low, `idle` is high, and every segment register holds selector 0 and cached base 0.
- R2: In real mode (`req_mode` = 2'b00) the result is `{selector, 4'b0000}` plus offset bits [15:0], kept to 21 bits with the carry into bit 20 preserved. Bits [31:21] are zero, offset bits [31:16] are ignored, and `lin_phys` is 1 whatever the value of `paging_en`.
- R3: In virtual-8086 mode (`req_mode` = 2'b01) the address arithmetic is the same as in R2, and `lin_phys` equals the inverse of `paging_en` sampled with the request.
- R4: A protected-mode fetch (`req_mode[1]` = 1) reads the single 64-bit word at table base + selector[15:3] × 8. The table base is `ldt_base` when selector bit 2 is 1 and `gdt_base` when it is 0, both sampled with the request. `mem_addr` stays stable while `mem_req` waits for `mem_ack`.
- R5: The descriptor base is assembled from read-data bits [39:16] (base bits 23:0) and bits [63:56] (base bits 31:24). All other read-data bits have no effect.
- R6: A protected-mode result is descriptor base + offset, wrapping modulo 2^32, and `lin_phys` equals the inverse of `paging_en`.
- R7: `req_src` encodings are 0 = explicit selector, 1 = CS, 2 = DS, 3 = SS, 4 = ES. A load (`req_load` = 1, source 1 to 4) in protected mode fetches the descriptor, stores both selector and base, and produces no output. A protected translation through a register uses the cached base, with no memory read.
- R8: In real or virtual-8086 mode, a translation through a register uses that register's stored selector × 16 and ignores its cached base.
- R9: A translation that needs no fetch gives `out_valid` in the cycle after it is accepted. A fetching translation gives `out_valid` in the cycle after `mem_ack`. `idle` is low from acceptance until the acknowledge, and any request presented while `idle` is low is ignored.
- R10: A load in real or virtual-8086 mode completes at once with no memory read and no output, and sets the cached base to selector × 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `idle` is high |
| req_load | input | 1 | 1 = load segment register, 0 = translate |
| req_mode | input | 2 | 00 real, 01 virtual-8086, 1x protected |
| req_src | input | 3 | Selector source (R7 encoding) |
| req_sel | input | 16 | Explicit selector, or selector to load |
| req_off | input | 32 | Offset |
| paging_en | input | 1 | Page translation enabled |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| idle | output | 1 | Ready to accept a request |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 64 | Descriptor read data |
| out_valid | output | 1 | Result valid for one cycle |
| lin_addr | output | 32 | Linear address |
| lin_phys | output | 1 | 1 = address is final physical |

## Verification
The bench builds the block with its default of four segment registers. It drives the memory port from a behavioural responder whose acknowledge delay changes between tests, from 0 to 3 cycles. Varying that delay exercises the fetch latency and the address-hold rule under both back-to-back and stalled acknowledges. Descriptors are filled with marker bytes outside the base fields, so any wrong byte choice shows up in the linear address. Selectors of 0xFFFF, offsets near 2^32 and registers loaded in one mode but used in another reach the carry, wrap and cache-bypass corners.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W      = 16;
  localparam int LIN_W      = 32;
  localparam int DESC_W     = 64;
  localparam int REAL_OFF_W = 16;
  localparam int REAL_SUM_W = SEL_W + 5;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_V86  = 2'b01,
    MODE_PROT = 2'b10,
    MODE_PRX  = 2'b11
  } cpu_mode_e;

  typedef enum logic [2:0] {
    SRC_EXPL = 3'd0,
    SRC_CS   = 3'd1,
    SRC_DS   = 3'd2,
    SRC_SS   = 3'd3,
    SRC_ES   = 3'd4
  } seg_src_e;

  typedef struct packed {
    logic             load;
    logic [1:0]       idx;
    logic [SEL_W-1:0] sel;
    logic [LIN_W-1:0] off;
    logic             paging;
    logic [LIN_W-1:0] daddr;
  } fetch_op_t;

  function automatic logic mode_is_prot(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic [LIN_W-1:0] shifted_base(input logic [SEL_W-1:0] sel);
    return LIN_W'({sel, 4'b0000});
  endfunction

  // 21-bit sum, carry kept, upper offset bits dropped
  function automatic logic [LIN_W-1:0] real_lin(input logic [SEL_W-1:0] sel,
                                                input logic [LIN_W-1:0] off);
    logic [REAL_SUM_W-1:0] s;
    s = {1'b0, sel, 4'b0000} + {5'b0, off[REAL_OFF_W-1:0]};
    return LIN_W'(s);
  endfunction

  function automatic logic [LIN_W-1:0] desc_addr(input logic [SEL_W-1:0] sel,
                                                 input logic [LIN_W-1:0] gdt,
                                                 input logic [LIN_W-1:0] ldt);
    logic [LIN_W-1:0] tbl;
    tbl = sel[2] ? ldt : gdt;
    return tbl + LIN_W'({sel[SEL_W-1:3], 3'b000});
  endfunction

  function automatic logic [LIN_W-1:0] desc_base(input logic [DESC_W-1:0] d);
    return {d[63:56], d[39:16]};
  endfunction

  function automatic logic [LIN_W-1:0] prot_lin(input logic [LIN_W-1:0] base,
                                                input logic [LIN_W-1:0] off);
    return base + off;
  endfunction
endpackage

// File: rtl/seg_sreg_cache.sv
module seg_sreg_cache
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SREG = 4,
  localparam int IDX_W = (NUM_SREG > 1) ? $clog2(NUM_SREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [LIN_W-1:0] wr_base,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEL_W-1:0] rd_sel,
  output logic [LIN_W-1:0] rd_base
);
  logic [SEL_W-1:0] sel_q  [NUM_SREG];
  logic [LIN_W-1:0] base_q [NUM_SREG];

  for (genvar g = 0; g < NUM_SREG; g++) begin : g_sreg
    wire hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g]  <= '0;
        base_q[g] <= '0;
      end else if (hit) begin
        sel_q[g]  <= wr_sel;
        base_q[g] <= wr_base;
      end
    end
  end

  assign rd_sel  = sel_q[rd_idx];
  assign rd_base = base_q[rd_idx];
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fetch_op_t         start_op,
  output logic              idle,
  output logic              mem_req,
  output logic [LIN_W-1:0]  mem_addr,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              done,
  output fetch_op_t         done_op,
  output logic [LIN_W-1:0]  done_base
);
  typedef enum logic {FS_IDLE, FS_WAIT} fstate_e;
  fstate_e   state;
  fetch_op_t op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_IDLE;
      op_q  <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (start) begin
          op_q  <= start_op;
          state <= FS_WAIT;
        end
        FS_WAIT: if (mem_ack) state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign idle      = (state == FS_IDLE);
  assign mem_req   = (state == FS_WAIT);
  assign mem_addr  = op_q.daddr;
  assign done      = mem_req && mem_ack;
  assign done_op   = op_q;
  assign done_base = desc_base(mem_rdata);

  // R4
  fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R9
  start_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_req && !idle);
  // R9
  wait_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !idle);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SREG = 4,
  localparam int IDX_W = (NUM_SREG > 1) ? $clog2(NUM_SREG) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_load,
  input  logic [1:0]  req_mode,
  input  logic [2:0]  req_src,
  input  logic [15:0] req_sel,
  input  logic [31:0] req_off,
  input  logic        paging_en,
  input  logic [31:0] gdt_base,
  input  logic [31:0] ldt_base,
  output logic        idle,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        out_valid,
  output logic [31:0] lin_addr,
  output logic        lin_phys
);
  // request decode
  wire             accept   = req_valid && idle;
  wire             use_reg  = (req_src >= 3'(SRC_CS)) && (req_src <= 3'(SRC_ES));
  wire [IDX_W-1:0] sreg_idx = IDX_W'(req_src - 3'd1);
  wire             prot     = mode_is_prot(req_mode);
  wire             is_real  = (req_mode == MODE_REAL);

  logic [SEL_W-1:0] rd_sel;
  logic [LIN_W-1:0] rd_base;
  wire  [SEL_W-1:0] sel_eff = use_reg ? rd_sel : req_sel;

  // named events
  wire need_fetch = prot && (req_load ? use_reg : !use_reg);
  wire start      = accept && need_fetch;
  wire hit_fire   = accept && !req_load && !need_fetch;
  wire imm_load   = accept && req_load && use_reg && !prot;

  fetch_op_t  start_op;
  fetch_op_t  done_op;
  logic       fetch_done;
  logic [LIN_W-1:0] done_base;

  always_comb begin
    start_op        = '0;
    start_op.load   = req_load;
    start_op.idx    = 2'(sreg_idx);
    start_op.sel    = req_sel;
    start_op.off    = req_off;
    start_op.paging = paging_en;
    start_op.daddr  = desc_addr(req_sel, gdt_base, ldt_base);
  end

  seg_fetch_ctrl u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_op  (start_op),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (fetch_done),
    .done_op   (done_op),
    .done_base (done_base)
  );

  // segment register write port
  wire              fetch_load = fetch_done && done_op.load;
  wire              cw_en   = imm_load || fetch_load;
  wire [IDX_W-1:0]  cw_idx  = fetch_load ? IDX_W'(done_op.idx) : sreg_idx;
  wire [SEL_W-1:0]  cw_sel  = fetch_load ? done_op.sel : req_sel;
  wire [LIN_W-1:0]  cw_base = fetch_load ? done_base : shifted_base(req_sel);

  seg_sreg_cache #(.NUM_SREG(NUM_SREG)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cw_en),
    .wr_idx  (cw_idx),
    .wr_sel  (cw_sel),
    .wr_base (cw_base),
    .rd_idx  (sreg_idx),
    .rd_sel  (rd_sel),
    .rd_base (rd_base)
  );

  // result register
  wire fetch_out = fetch_done && !done_op.load;
  logic res_real;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      lin_phys  <= 1'b0;
      res_real  <= 1'b0;
    end else begin
      out_valid <= hit_fire || fetch_out;
      if (fetch_out) begin
        lin_addr <= prot_lin(done_base, done_op.off);
        lin_phys <= !done_op.paging;
        res_real <= 1'b0;
      end else if (hit_fire) begin
        lin_addr <= prot ? prot_lin(rd_base, req_off) : real_lin(sel_eff, req_off);
        lin_phys <= is_real || !paging_en;
        res_real <= is_real;
      end
    end
  end

  // R7
  cached_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> out_valid && !mem_req);
  // R2
  real_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_real |-> lin_addr[31:21] == 11'd0 && lin_phys);
  // R9
  ack_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_out |=> out_valid && idle);
  // R10
  real_load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_load |=> !mem_req && !out_valid);
endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_load = 1'b0, paging_en = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic [2:0]  req_src = 3'd0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [31:0] gdt_base = 32'h0010_0000, ldt_base = 32'h0020_0800;
  logic        idle, mem_req, mem_ack = 1'b0, out_valid, lin_phys;
  logic [31:0] mem_addr, lin_addr;
  logic [63:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int mem_delay = 0, mem_reads = 0, wait_cnt = 0;
  logic [31:0] last_addr = '0;
  bit out_window = 1'b0;

  longint ref_sel  [4];
  longint ref_base [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
    .req_mode(req_mode), .req_src(req_src), .req_sel(req_sel), .req_off(req_off),
    .paging_en(paging_en), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .lin_addr(lin_addr),
    .lin_phys(lin_phys)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural descriptor contents
  function automatic longint model_base(input longint addr);
    return ((addr * 64'd2654435761) + 64'h0135_79BD) & 64'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] model_desc(input longint addr);
    longint b;
    b = model_base(addr);
    return {b[31:24], 8'hA5, 8'h5A, b[23:0], 16'hC3C3};
  endfunction

  function automatic longint model_daddr(input longint sel);
    longint tbl;
    tbl = ((sel / 4) % 2 == 1) ? longint'(ldt_base) : longint'(gdt_base);
    return (tbl + (sel / 8) * 8) & 64'hFFFF_FFFF;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt >= mem_delay) begin
          mem_ack = 1'b1;
          mem_rdata = model_desc(longint'(mem_addr));
          last_addr = mem_addr;
          mem_reads++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  // every-cycle monitor: no stray result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && !out_window) begin
        checks++; failures++;
        $display("FAIL R9 stray out_valid actual=1 expected=0");
      end
    end
  end

  task automatic drive(input bit ld, input logic [1:0] m, input logic [2:0] s,
                       input logic [15:0] sel, input logic [31:0] off, input bit pg);
    @(negedge clk);
    req_valid = 1'b1; req_load = ld; req_mode = m; req_src = s;
    req_sel = sel; req_off = off; paging_en = pg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // translate and compare with model; junk = poke a request while busy
  task automatic xlate(input string tag, input logic [1:0] m, input logic [2:0] s,
                       input logic [15:0] sel, input logic [31:0] off, input bit pg,
                       input bit junk);
    longint esel, ebase, elin, ephys;
    bit fetch;
    int n, reads0, lat;
    reads0 = mem_reads;
    esel = (s >= 1 && s <= 4) ? ref_sel[s-1] : longint'(sel);
    fetch = m[1] && !(s >= 1 && s <= 4);
    if (!m[1]) elin = (esel * 16 + (longint'(off) % 65536));
    else begin
      ebase = (s >= 1 && s <= 4) ? ref_base[s-1] : model_base(model_daddr(esel));
      elin = (ebase + longint'(off)) % 64'h1_0000_0000;
    end
    ephys = (m == 2'b00) ? 1 : (pg ? 0 : 1);
    out_window = 1'b1;
    drive(1'b0, m, s, sel, off, pg);
    n = 1;
    if (fetch) chk({tag, " R9 idle low while fetching"}, idle, 0);
    if (junk && fetch) begin
      req_valid = 1'b1; req_load = 1'b0; req_mode = 2'b00; req_src = 3'd0;
      req_sel = 16'h7777; req_off = 32'h1;
      @(negedge clk); req_valid = 1'b0; n++;
    end
    while (!out_valid && n < 30) begin @(negedge clk); n++; end
    lat = fetch ? mem_delay + 2 : 1;
    chk({tag, " R9 latency"}, n, lat);
    chk({tag, " linear address"}, lin_addr, elin);
    chk({tag, " phys flag"}, lin_phys, ephys);
    chk({tag, " R7 read count"}, mem_reads - reads0, fetch ? 1 : 0);
    if (fetch) chk({tag, " R4 descriptor address"}, last_addr, model_daddr(esel));
    @(negedge clk);
    out_window = 1'b0;
    chk({tag, " R9 single result"}, out_valid, 0);
  endtask

  task automatic load(input string tag, input logic [1:0] m, input logic [2:0] s,
                      input logic [15:0] sel);
    int reads0, n;
    reads0 = mem_reads;
    drive(1'b1, m, s, sel, 32'h0, 1'b0);
    n = 0;
    while (!idle && n < 30) begin @(negedge clk); n++; end
    @(negedge clk);
    chk({tag, " read count"}, mem_reads - reads0, m[1] ? 1 : 0);
    if (m[1]) chk({tag, " R4 descriptor address"}, last_addr, model_daddr(sel));
    ref_sel[s-1] = sel;
    ref_base[s-1] = m[1] ? model_base(model_daddr(sel)) : longint'(sel) * 16;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ref_sel[i] = 0; ref_base[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 idle", idle, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 registers read as zero after reset (real via CS)
    xlate("R1 cs reset", 2'b00, 3'd1, 16'h0, 32'h0000_0042, 1'b1, 0);
    // R2 real mode, upper offset ignored, paging ignored
    xlate("R2 basic", 2'b00, 3'd0, 16'h1234, 32'h0005_ABCD, 1'b1, 0);
    xlate("R2 carry", 2'b00, 3'd0, 16'hFFFF, 32'hFFFF_FFFF, 1'b0, 0);
    // R3 virtual-8086
    xlate("R3 pg on", 2'b01, 3'd0, 16'hB800, 32'h0000_0100, 1'b1, 0);
    xlate("R3 pg off", 2'b01, 3'd0, 16'hB800, 32'h0001_0100, 1'b0, 0);
    // R4 R5 R6 protected explicit, global then local tables
    mem_delay = 0;
    xlate("R5 gdt", 2'b10, 3'd0, 16'h002B, 32'h0000_1000, 1'b1, 0);
    mem_delay = 3;
    xlate("R6 ldt wrap", 2'b11, 3'd0, 16'h0FFC, 32'hFFFF_FFF0, 1'b0, 0);
    // R9 request while busy is ignored
    mem_delay = 2;
    xlate("R9 busy ignore", 2'b10, 3'd0, 16'h0060, 32'h0000_0004, 1'b0, 1);
    // R7 protected load, cached use
    mem_delay = 1;
    load("R7 load ds", 2'b10, 3'd2, 16'h0055);
    xlate("R7 ds cached", 2'b10, 3'd2, 16'h0000, 32'h0000_0010, 1'b1, 0);
    mem_delay = 0;
    load("R7 load ss", 2'b10, 3'd3, 16'hFFF8);
    xlate("R7 ss cached", 2'b10, 3'd3, 16'h0000, 32'h8000_0000, 1'b0, 0);
    // R10 real-mode load without read
    load("R10 load es", 2'b00, 3'd4, 16'h0A00);
    xlate("R10 es real", 2'b00, 3'd4, 16'h0000, 32'h0000_FFFF, 1'b0, 0);
    xlate("R10 es prot base", 2'b10, 3'd4, 16'h0000, 32'h0000_0001, 1'b1, 0);
    // R8 v86 through DS uses selector, not cached descriptor base
    xlate("R8 ds v86", 2'b01, 3'd2, 16'h0000, 32'h0000_0020, 1'b1, 0);
    xlate("R8 ss real", 2'b00, 3'd3, 16'h0000, 32'h0000_0008, 1'b1, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule